// File: doc/BRIEF.md
# GPIO Interrupt Capture with Split Capture and Report Enables

This block watches a bank of general-purpose inputs and turns activity on them into per-pin pending flags and one combined interrupt line. Each input first passes through a two-flop synchroniser. A per-pin detector then fires on one of four trigger types: active-high level, active-low level, rising edge or falling edge. When a pin's detector fires and capture is permitted for that pin, the pin's pending flag is set. The flag stays set until software acknowledges it.

Two independent per-pin permissions control the path. The capture enable decides whether detector hits can set the pending flag at all. The report enable decides whether a set flag drives the combined interrupt. Keeping them separate lets software handle a level source correctly. If software stops capture before it acknowledges the flag, a level input that is still held active will not set the flag again.

Software reaches four registers through a single-cycle write port and a combinational read port. Register 0 holds the trigger types. Register 1 holds the capture enables. Register 2 holds the report enables. Register 3 holds the pending flags and is acknowledged by writing ones to it.

Top module: `gpio_irq_latch`

## Requirements
- R1: After reset, every pending flag, capture enable, report enable and trigger field reads zero, and `irq` is low.
- R2: A pin whose capture enable is 0 never gets its pending flag set, whatever its input does.
- R3: Trigger field of pin i sits at register 0 bits [2i+1:2i]. Code 00 is level high, 01 is level low, 10 is rising edge and 11 is falling edge. A qualifying input change becomes visible in the pending register after the third rising clock edge following the change.
- R4: `irq` is high exactly when at least one pin has both its pending flag and its report enable set.
- R5: With capture enabled and report disabled, a pin's pending flag still sets, but `irq` stays low until the report enable is written to 1.
- R6: Writing to register 3 clears each pending flag whose data bit is 1 and leaves flags whose data bit is 0 untouched.
- R7: When a detector hit and an acknowledge reach the same pin in the same cycle, the flag stays set. A level pin with capture on and its input still active therefore reads pending again right after the acknowledge.
- R8: A level pin whose capture enable is cleared before the acknowledge stays clear after the acknowledge, even while its input stays active.
- R9: Turning on capture for an edge-type pin does not by itself set the flag. This holds even if the input moved while capture was off. An edge that arrives after the enable is captured.
- R10: Registers 0, 1 and 2 read back what was written, masked to the implemented width (2 bits per pin for register 0, 1 bit per pin for registers 1 and 2). Unused high bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | NPINS | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 2 | Register index for both read and write |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt |

## Verification
The bench sweeps every trigger type, every pin, and every start and end level of the input. For each case it predicts the pending bit and `irq`, so a swapped trigger code or a wrong edge polarity shows up as a wrong pending bit. The level re-latch after an acknowledge is checked twice: once with capture still on, where a design that lets the clear win would lose the pending flag, and once with capture off, where a design that captures through the report enable would set it again. The bench also moves an edge-type input while capture is off and then enables capture. A detector that does not resample its history on enable would report a phantom edge there. Partial acknowledges check that only the written bits clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRG_LVL_HI = 2'b00,
    TRG_LVL_LO = 2'b01,
    TRG_RISE   = 2'b10,
    TRG_FALL   = 2'b11
  } trig_e;

  localparam logic [1:0] REG_TRIG  = 2'd0;
  localparam logic [1:0] REG_CAPEN = 2'd1;
  localparam logic [1:0] REG_REPEN = 2'd2;
  localparam logic [1:0] REG_PEND  = 2'd3;

  // Detector decision for one pin; edges need a fresh history (armed).
  function automatic logic trig_hit(input logic [1:0] mode, input logic cur,
                                    input logic prev, input logic armed);
    logic h;
    case (trig_e'(mode))
      TRG_LVL_HI: h = cur;
      TRG_LVL_LO: h = ~cur;
      TRG_RISE:   h = armed & cur & ~prev;
      default:    h = armed & ~cur & prev;
    endcase
    return h;
  endfunction

  function automatic logic is_edge_mode(input logic [1:0] mode);
    return mode[1];
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cur,
  input  logic       cap_en,
  input  logic [1:0] mode,
  output logic       hit,
  output logic       armed
);
  logic prev_q;
  logic armed_q;

  // History only follows the pin while capture is on; the cycle right
  // after enabling reloads it and suppresses edge decisions.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= cap_en;
      if (cap_en) prev_q <= cur;
    end
  end

  assign armed = armed_q;
  assign hit   = cap_en & trig_hit(mode, cur, prev_q, armed_q);
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] pend
);
  logic [N-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | set_vec;
  end

  assign pend = pend_q;
endmodule

// File: rtl/gpio_irq_latch.sv
module gpio_irq_latch
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] gpio_in,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             irq
);
  localparam int TW = 2 * NPINS;

  logic [TW-1:0]    trig_q;
  logic [NPINS-1:0] cap_en_q;
  logic [NPINS-1:0] rep_en_q;
  logic [NPINS-1:0] pin_s;
  logic [NPINS-1:0] hit_vec;
  logic [NPINS-1:0] armed_vec;
  logic [NPINS-1:0] set_vec;
  logic [NPINS-1:0] clr_vec;
  logic [NPINS-1:0] pend_q;

  gpio_irq_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(pin_s)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_irq_detect u_det (
      .clk(clk), .rst_n(rst_n), .cur(pin_s[i]), .cap_en(cap_en_q[i]),
      .mode(trig_q[2*i +: 2]), .hit(hit_vec[i]), .armed(armed_vec[i])
    );
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q   <= '0;
      cap_en_q <= '0;
      rep_en_q <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_TRIG:  trig_q   <= wdata[TW-1:0];
        REG_CAPEN: cap_en_q <= wdata[NPINS-1:0];
        REG_REPEN: rep_en_q <= wdata[NPINS-1:0];
        default:   ;
      endcase
    end
  end

  assign set_vec = hit_vec & cap_en_q;
  assign clr_vec = (wr_en && addr == REG_PEND) ? wdata[NPINS-1:0] : '0;

  gpio_irq_status #(.N(NPINS)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .pend(pend_q)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      REG_TRIG:  rdata[TW-1:0]    = trig_q;
      REG_CAPEN: rdata[NPINS-1:0] = cap_en_q;
      REG_REPEN: rdata[NPINS-1:0] = rep_en_q;
      default:   rdata[NPINS-1:0] = pend_q;
    endcase
  end

  assign irq = |(pend_q & rep_en_q);
endmodule

// File: rtl/gpio_irq_latch_chk.sv
module gpio_irq_latch_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [N-1:0] pend,
  input logic [N-1:0] cap_en,
  input logic [N-1:0] rep_en,
  input logic [N-1:0] set_vec,
  input logic [N-1:0] clr_vec,
  input logic         irq
);
  // R2: a flag can only rise where capture was enabled
  a_r2_no_capture_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(cap_en)) == '0);

  // R4: a reported capture raises irq on the next cycle
  a_r4_irq_follows_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(set_vec & rep_en)) && !wr_en) |=> irq);

  // R6: an acknowledged flag without a new hit clears
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & $past(clr_vec) & ~$past(set_vec)) == '0);

  // R7: a hit always lands, even against an acknowledge
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & $past(set_vec)) == $past(set_vec));
endmodule

bind gpio_irq_latch gpio_irq_latch_chk #(.N(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pend(pend_q), .cap_en(cap_en_q),
  .rep_en(rep_en_q), .set_vec(set_vec), .clr_vec(clr_vec), .irq(irq)
);

// File: tb/test_gpio_irq_latch.sv
module test_gpio_irq_latch;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] gpio_in = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_latch #(.NPINS(NP), .DW(DW)) i_gpio_irq_latch (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wr_en = 1'b1; addr = a; wdata = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    addr = a; #1; d = int'(rdata);
  endtask

  function automatic int rep_trig(input int t);
    int v = 0;
    for (int i = 0; i < NP; i++) v |= (t & 3) << (2 * i);
    return v;
  endfunction

  // Expected pending after: ack while input at a, then input moves to b
  function automatic int expect_flag(input int t, input int a, input int b);
    case (t)
      0: return (a | b);
      1: return ((1 - a) | (1 - b));
      2: return ((1 - a) & b);
      default: return (a & (1 - b));
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v;
    int e;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1: reset state
    for (int r = 0; r < 4; r++) begin
      rd(r[1:0], v);
      check("R1 register after reset", v, 0);
    end
    check("R1 irq after reset", int'(irq), 0);

    // R10: readback and width masking
    wr(2'd0, 8'hB4); rd(2'd0, v); check("R10 trigger readback", v, 'hB4);
    wr(2'd1, 8'hFF); rd(2'd1, v); check("R10 capture readback", v, 'hF);
    wr(2'd2, 8'hA5); rd(2'd2, v); check("R10 report readback", v, 'h5);
    wr(2'd1, 0); wr(2'd2, 0); wr(2'd0, 0);

    // R3 / R4 / R2 sweep: trigger type x pin x start level x end level
    for (int t = 0; t < 4; t++)
      for (int p = 0; p < NP; p++)
        for (int a = 0; a < 2; a++)
          for (int b = 0; b < 2; b++) begin
            gpio_in = a ? '1 : '0;
            wr(2'd0, rep_trig(t));
            wr(2'd1, 1 << p);
            wr(2'd2, 1 << p);
            tick(4);
            wr(2'd3, 'hF);
            gpio_in = b ? '1 : '0;
            tick(3);
            e = expect_flag(t, a, b);
            rd(2'd3, v);
            check($sformatf("R3 R2 pending t=%0d p=%0d a=%0d b=%0d", t, p, a, b), v, e << p);
            check($sformatf("R4 irq t=%0d p=%0d", t, p), int'(irq), e);
          end

    wr(2'd1, 0); wr(2'd2, 0); wr(2'd0, 0); gpio_in = '0; tick(4); wr(2'd3, 'hF);

    // R5: capture on, report off
    wr(2'd1, 1);
    gpio_in[0] = 1'b1; tick(3);
    rd(2'd3, v); check("R5 flag sets with report off", v, 1);
    check("R5 irq stays low", int'(irq), 0);
    wr(2'd2, 1); #1;
    check("R4 irq after report enable", int'(irq), 1);

    // R7: ack against held level, capture on
    wr(2'd3, 1); rd(2'd3, v); check("R7 level relatches after ack", v, 1);
    check("R7 irq still high", int'(irq), 1);

    // R8: capture off before ack
    wr(2'd1, 0); wr(2'd3, 1); tick(5);
    rd(2'd3, v); check("R8 stays clear with level held", v, 0);
    check("R8 irq low", int'(irq), 0);
    gpio_in[0] = 1'b0;

    // R6: partial acknowledge on edge pins 1 and 2
    wr(2'd0, (2 << 2) | (2 << 4));
    wr(2'd1, 'h6);
    tick(3);
    gpio_in[2:1] = 2'b11; tick(3);
    rd(2'd3, v); check("R6 both edges latched", v, 'h6);
    wr(2'd3, 'h2); rd(2'd3, v); check("R6 only written bit clears", v, 'h4);
    wr(2'd3, 'h0); rd(2'd3, v); check("R6 zero write leaves flags", v, 'h4);
    wr(2'd3, 'h4); rd(2'd3, v); check("R6 remaining bit clears", v, 0);

    // R9: input moves while capture off, then enable
    wr(2'd1, 0);
    wr(2'd0, 2 << 6);
    gpio_in[3] = 1'b1; tick(4);
    wr(2'd1, 'h8); tick(4);
    rd(2'd3, v); check("R9 no phantom edge on enable", v, 0);
    gpio_in[3] = 1'b0; tick(4);
    gpio_in[3] = 1'b1; tick(3);
    rd(2'd3, v); check("R9 edge after enable captured", v, 'h8);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule